// File: doc/BRIEF.md
# Reduced-Round PRINCE Keystream Core

This block is a 64-bit block cipher core in the PRINCE family. It turns a 64-bit input word into a 64-bit output word under a 128-bit key. It is meant for counter mode: a caller feeds it a counter value, such as a nonce joined with a memory address, and XORs the result with stored data. The caller thereby scrambles or unscrambles memory contents without ever running the cipher backwards, so only the encrypt direction is built.

The number of half-rounds on each side of the middle layer is a parameter from 0 to 5. With 5 the core is the full twelve-round cipher. Smaller values trade strength for less logic depth. The key schedule uses the alternative form: the two key halves take turns as the round key, and the output whitening key is derived from the high half.

The whole datapath is one combinational pass, followed by an output register. A request presented with its valid strobe produces a result one clock later. A new request can be accepted every cycle.

Top module: `prince_ks_core`

## Requirements
- R1: `out_valid_o` is high in the cycle after a clock edge at which `in_valid_i` was high, and low after an edge at which `in_valid_i` was low. Back-to-back requests give one result per cycle.
- R2: While `rst_ni` is low at a clock edge, the output register clears: after that edge `out_valid_o` is 0 and `out_data_o` is all zeros.
- R3: When `in_valid_i` is low at a clock edge, `out_data_o` keeps its previous value whatever `in_data_i` and `in_key_i` carry.
- R4: With `HALF_ROUNDS` = 5 and an all-zero key, an all-zero input gives 818665AA0D02DFDA, and an all-ones input gives 604AE6CA03C20ADA.
- R5: The key splits into k0 = key[127:64] and k1 = key[63:0]. The state starts as data ^ k0 ^ k1. The output whitening key k0' is k0 rotated right by one bit, XORed with k0 >> 63.
- R6: Forward half-round r (r = 1..N) applies the S-box layer, then M', then the forward nibble shuffle, then XOR with constant r, then XOR with the round key: k0 for odd r, k1 for even r.
- R7: Between the two halves, the state passes through the S-box layer, then M', then the inverse S-box layer.
- R8: Inverse half-round j (j = 0..N-1) uses index r = 11-N+j. It XORs the round key (k1 for odd r, k0 for even r), then constant r, then applies the inverse nibble shuffle, then M', then the inverse S-box layer. The last step XORs constant 11, then k1, then k0'.
- R9: Nibble i is bits [4i+3:4i]. The S-box maps 0..F to B,F,3,2,A,C,9,1,6,7,8,0,E,5,D,4. Forward shuffle output nibble n takes input nibble [4,9,E,3,8,D,2,7,C,1,6,B,0,5,A,F][n].
- R10: M' works on each 16-bit block b separately. Output nibble n of block b is the XOR of the four nibbles of (block AND mask[(s+3-n) mod 4]). The masks are 7BDE, BDE7, DE7B, E7BD, and s is 0 for blocks 0 and 3 and 1 for blocks 1 and 2.
- R11: Constant 0 is zero. Constants 1 to 11 are the standard PRINCE constants, from 13198A2E03707344 to C0AC29B7C97C50DD.
- R12: With `HALF_ROUNDS` = 0, the result is the initial whitening, the middle layer and the final step only.
- R13: Under a fixed key the mapping is a permutation: two consecutive requests with equal keys and different inputs give different results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| in_data_i | input | 64 | Input block (counter value) |
| in_key_i | input | 128 | Cipher key, k0 in the upper half |
| out_valid_o | output | 1 | Result strobe, one cycle after the request |
| out_data_o | output | 64 | Keystream result |

## Verification
The assertions check the timing on every cycle: the one-cycle valid latency, the clearing under reset, the output holding while no request arrives, and the permutation property between consecutive requests under one key. Whether the output value is numerically right can only be shown by the bench. The bench compares against published answers for the full-round, zero-key case, and against an independent model across key splits, round-key alternation and the zero-half-round variant.

// File: rtl/prince_ks_pkg.sv
// Shared constants and layer functions for the PRINCE keystream core.
// Assumes a 64-bit state of sixteen nibbles, nibble i at bits [4i+3:4i].
package prince_ks_pkg;

    localparam int BLK_W     = 64;
    localparam int KEY_W     = 2 * BLK_W;
    localparam int NIB_N     = BLK_W / 4;
    localparam int GRP_N     = BLK_W / 16;
    localparam int LAST_RC   = 11;
    localparam int MAX_HALF  = 5;

    typedef logic [BLK_W-1:0] blk_t;

    // Forward 4-bit substitution
    function automatic logic [3:0] sub4(input logic [3:0] v);
        case (v)
            4'h0: sub4 = 4'hB;  4'h1: sub4 = 4'hF;
            4'h2: sub4 = 4'h3;  4'h3: sub4 = 4'h2;
            4'h4: sub4 = 4'hA;  4'h5: sub4 = 4'hC;
            4'h6: sub4 = 4'h9;  4'h7: sub4 = 4'h1;
            4'h8: sub4 = 4'h6;  4'h9: sub4 = 4'h7;
            4'hA: sub4 = 4'h8;  4'hB: sub4 = 4'h0;
            4'hC: sub4 = 4'hE;  4'hD: sub4 = 4'h5;
            4'hE: sub4 = 4'hD;  default: sub4 = 4'h4;
        endcase
    endfunction

    // Inverse 4-bit substitution
    function automatic logic [3:0] sub4_inv(input logic [3:0] v);
        case (v)
            4'h0: sub4_inv = 4'hB;  4'h1: sub4_inv = 4'h7;
            4'h2: sub4_inv = 4'h3;  4'h3: sub4_inv = 4'h2;
            4'h4: sub4_inv = 4'hF;  4'h5: sub4_inv = 4'hD;
            4'h6: sub4_inv = 4'h8;  4'h7: sub4_inv = 4'h9;
            4'h8: sub4_inv = 4'hA;  4'h9: sub4_inv = 4'h6;
            4'hA: sub4_inv = 4'h4;  4'hB: sub4_inv = 4'h0;
            4'hC: sub4_inv = 4'h5;  4'hD: sub4_inv = 4'hE;
            4'hE: sub4_inv = 4'hC;  default: sub4_inv = 4'h1;
        endcase
    endfunction

    // Substitution over all nibbles, forward or inverse
    function automatic blk_t sub_layer(input blk_t x, input logic inv);
        blk_t r;
        for (int i = 0; i < NIB_N; i++) begin
            r[4*i +: 4] = inv ? sub4_inv(x[4*i +: 4]) : sub4(x[4*i +: 4]);
        end
        return r;
    endfunction

    // Diffusion mask selected by rotating index
    function automatic logic [15:0] mix_mask(input logic [1:0] idx);
        case (idx)
            2'd0:    mix_mask = 16'h7BDE;
            2'd1:    mix_mask = 16'hBDE7;
            2'd2:    mix_mask = 16'hDE7B;
            default: mix_mask = 16'hE7BD;
        endcase
    endfunction

    // M' layer: per 16-bit group, nibble-folded masked parity
    function automatic blk_t mix_layer(input blk_t x);
        blk_t        r;
        logic [15:0] grp;
        logic [15:0] msk;
        logic [1:0]  base;
        logic [1:0]  sel;
        for (int g = 0; g < GRP_N; g++) begin
            grp  = x[16*g +: 16];
            base = (g == 0 || g == GRP_N - 1) ? 2'd0 : 2'd1;
            for (int n = 0; n < 4; n++) begin
                sel = base + 2'd3 - 2'(n);
                msk = grp & mix_mask(sel);
                r[16*g + 4*n +: 4] = msk[3:0] ^ msk[7:4] ^ msk[11:8] ^ msk[15:12];
            end
        end
        return r;
    endfunction

    // Source nibble of the forward shuffle for destination n
    function automatic int shuffle_src(input int n);
        case (n)
            0:  shuffle_src = 4;   1:  shuffle_src = 9;
            2:  shuffle_src = 14;  3:  shuffle_src = 3;
            4:  shuffle_src = 8;   5:  shuffle_src = 13;
            6:  shuffle_src = 2;   7:  shuffle_src = 7;
            8:  shuffle_src = 12;  9:  shuffle_src = 1;
            10: shuffle_src = 6;   11: shuffle_src = 11;
            12: shuffle_src = 0;   13: shuffle_src = 5;
            14: shuffle_src = 10;  default: shuffle_src = 15;
        endcase
    endfunction

    // Nibble shuffle; the inverse scatters along the same map
    function automatic blk_t shuffle(input blk_t x, input logic inv);
        blk_t r;
        for (int n = 0; n < NIB_N; n++) begin
            if (inv) r[4*shuffle_src(n) +: 4] = x[4*n +: 4];
            else     r[4*n +: 4]              = x[4*shuffle_src(n) +: 4];
        end
        return r;
    endfunction

    // Round constant by index 0..11
    function automatic blk_t round_const(input int idx);
        case (idx)
            0:  round_const = 64'h0000000000000000;
            1:  round_const = 64'h13198A2E03707344;
            2:  round_const = 64'hA4093822299F31D0;
            3:  round_const = 64'h082EFA98EC4E6C89;
            4:  round_const = 64'h452821E638D01377;
            5:  round_const = 64'hBE5466CF34E90C6C;
            6:  round_const = 64'h7EF84F78FD955CB1;
            7:  round_const = 64'h85840851F1AC43AA;
            8:  round_const = 64'hC882D32F25323C54;
            9:  round_const = 64'h64A51195E0E3610D;
            10: round_const = 64'hD3B5A399CA0C2399;
            default: round_const = 64'hC0AC29B7C97C50DD;
        endcase
    endfunction

endpackage

// File: rtl/prince_ks_fwd_half.sv
// One forward half-round of the cipher, purely combinational.
// Assumes the caller has already picked the round key for this index.
module prince_ks_fwd_half
    import prince_ks_pkg::*;
#(
    parameter int RIDX = 1
) (
    input  logic [BLK_W-1:0] state_i,
    input  logic [BLK_W-1:0] rkey_i,
    output logic [BLK_W-1:0] state_o
);

    localparam blk_t RC = round_const(RIDX);

    // Substitute, diffuse, shuffle, then add constant and key
    always_comb begin
        state_o = shuffle(mix_layer(sub_layer(state_i, 1'b0)), 1'b0) ^ RC ^ rkey_i;
    end

endmodule

// File: rtl/prince_ks_inv_half.sv
// One inverse half-round of the cipher, purely combinational.
// Assumes the caller has already picked the round key for this index.
module prince_ks_inv_half
    import prince_ks_pkg::*;
#(
    parameter int RIDX = 10
) (
    input  logic [BLK_W-1:0] state_i,
    input  logic [BLK_W-1:0] rkey_i,
    output logic [BLK_W-1:0] state_o
);

    localparam blk_t RC = round_const(RIDX);

    // Add key and constant, unshuffle, diffuse, inverse substitute
    always_comb begin
        state_o = sub_layer(mix_layer(shuffle(state_i ^ rkey_i ^ RC, 1'b1)), 1'b1);
    end

endmodule

// File: rtl/prince_ks_middle.sv
// Middle layer between the two halves: S-box, M', inverse S-box.
// Keyless and combinational.
module prince_ks_middle
    import prince_ks_pkg::*;
(
    input  logic [BLK_W-1:0] state_i,
    output logic [BLK_W-1:0] state_o
);

    // Reflection step of the cipher
    always_comb begin
        state_o = sub_layer(mix_layer(sub_layer(state_i, 1'b0)), 1'b1);
    end

endmodule

// File: rtl/prince_ks_datapath.sv
// Full unrolled cipher datapath with HALF_ROUNDS half-rounds per side.
// Assumes 0 <= HALF_ROUNDS <= 5; combinational from inputs to result.
module prince_ks_datapath
    import prince_ks_pkg::*;
#(
    parameter int HALF_ROUNDS = 2
) (
    input  logic [BLK_W-1:0] data_i,
    input  logic [KEY_W-1:0] key_i,
    output logic [BLK_W-1:0] data_o
);

    localparam int FIRST_INV = LAST_RC - HALF_ROUNDS;

    logic [BLK_W-1:0] k0, k1, k0_out;
    logic [BLK_W-1:0] fwd_st [0:HALF_ROUNDS];
    logic [BLK_W-1:0] inv_st [0:HALF_ROUNDS];

    // Split the key and derive the output whitening key
    always_comb begin
        k0     = key_i[KEY_W-1:BLK_W];
        k1     = key_i[BLK_W-1:0];
        k0_out = {k0[0], k0[BLK_W-1:1]} ^ {{(BLK_W-1){1'b0}}, k0[BLK_W-1]};
    end

    // Initial whitening
    always_comb begin
        fwd_st[0] = data_i ^ k0 ^ k1 ^ round_const(0);
    end

    for (genvar g = 0; g < HALF_ROUNDS; g++) begin : g_fwd
        localparam int RI = g + 1;
        prince_ks_fwd_half #(.RIDX(RI)) u_fwd (
            .state_i (fwd_st[g]),
            .rkey_i  ((RI % 2 == 1) ? k0 : k1),
            .state_o (fwd_st[g+1])
        );
    end

    prince_ks_middle u_mid (
        .state_i (fwd_st[HALF_ROUNDS]),
        .state_o (inv_st[0])
    );

    for (genvar g = 0; g < HALF_ROUNDS; g++) begin : g_inv
        localparam int RI = FIRST_INV + g;
        prince_ks_inv_half #(.RIDX(RI)) u_inv (
            .state_i (inv_st[g]),
            .rkey_i  ((RI % 2 == 1) ? k1 : k0),
            .state_o (inv_st[g+1])
        );
    end

    // Final constant and whitening
    always_comb begin
        data_o = inv_st[HALF_ROUNDS] ^ round_const(LAST_RC) ^ k1 ^ k0_out;
    end

endmodule

// File: rtl/prince_ks_core.sv
// Top of the keystream core: unrolled cipher followed by one output register.
// A request with in_valid_i yields its result one cycle later; the result
// holds while no request arrives. Reset is synchronous, active low.
module prince_ks_core
    import prince_ks_pkg::*;
#(
    parameter int HALF_ROUNDS = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             in_valid_i,
    input  logic [63:0]      in_data_i,
    input  logic [127:0]     in_key_i,
    output logic             out_valid_o,
    output logic [63:0]      out_data_o
);

    logic [BLK_W-1:0] ks_d;

    prince_ks_datapath #(.HALF_ROUNDS(HALF_ROUNDS)) u_dp (
        .data_i (in_data_i),
        .key_i  (in_key_i),
        .data_o (ks_d)
    );

    // Valid strobe follows the request by one cycle
    always_ff @(posedge clk_i) begin
        if (!rst_ni) out_valid_o <= 1'b0;
        else         out_valid_o <= in_valid_i;
    end

    // Result register loads only on a request
    always_ff @(posedge clk_i) begin
        if (!rst_ni)         out_data_o <= '0;
        else if (in_valid_i) out_data_o <= ks_d;
    end

endmodule

// File: rtl/prince_ks_core_chk.sv
// Timing and permutation checks for prince_ks_core, bound to every instance.
module prince_ks_core_chk (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         in_valid_i,
    input logic [63:0]  in_data_i,
    input logic [127:0] in_key_i,
    input logic         out_valid_o,
    input logic [63:0]  out_data_o
);

    p_reset_clear_r2: assert property (@(posedge clk_i)
        !rst_ni |=> (!out_valid_o && out_data_o == 64'h0));

    p_valid_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);

    p_valid_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o);

    p_hold_result_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> $stable(out_data_o));

    p_distinct_out_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && $past(out_valid_o)
         && $past(in_key_i, 1) == $past(in_key_i, 2)
         && $past(in_data_i, 1) != $past(in_data_i, 2))
        |-> out_data_o != $past(out_data_o));

endmodule

bind prince_ks_core prince_ks_core_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .in_key_i    (in_key_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
);

// File: tb/prince_ks_core_bench.sv
// Bench: a full-round instance and a zero-half-round instance share one stimulus.
module prince_ks_core_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vld = 1'b0;
    logic [63:0]  din = '0;
    logic [127:0] key = '0;
    logic         ov5, ov0;
    logic [63:0]  od5, od0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    prince_ks_core #(.HALF_ROUNDS(5)) u_prince_ks_core (
        .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vld), .in_data_i(din),
        .in_key_i(key), .out_valid_o(ov5), .out_data_o(od5)
    );

    prince_ks_core #(.HALF_ROUNDS(0)) u_prince_ks_core_n0 (
        .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vld), .in_data_i(din),
        .in_key_i(key), .out_valid_o(ov0), .out_data_o(od0)
    );

    // ---------------- independent reference model ----------------
    localparam logic [3:0] BSB [16] = '{4'hB,4'hF,4'h3,4'h2,4'hA,4'hC,4'h9,4'h1,
                                        4'h6,4'h7,4'h8,4'h0,4'hE,4'h5,4'hD,4'h4};
    localparam int BSR [16] = '{4,9,14,3,8,13,2,7,12,1,6,11,0,5,10,15};
    localparam logic [15:0] BMK [4] = '{16'h7BDE,16'hBDE7,16'hDE7B,16'hE7BD};
    localparam logic [63:0] BRC [12] = '{
        64'h0000000000000000, 64'h13198A2E03707344, 64'hA4093822299F31D0,
        64'h082EFA98EC4E6C89, 64'h452821E638D01377, 64'hBE5466CF34E90C6C,
        64'h7EF84F78FD955CB1, 64'h85840851F1AC43AA, 64'hC882D32F25323C54,
        64'h64A51195E0E3610D, 64'hD3B5A399CA0C2399, 64'hC0AC29B7C97C50DD};

    function automatic logic [63:0] m_sub(input logic [63:0] x, input bit inv);
        logic [63:0] r;
        for (int i = 0; i < 16; i++) begin
            if (!inv) r[4*i +: 4] = BSB[x[4*i +: 4]];
            else begin
                for (int v = 0; v < 16; v++)
                    if (BSB[v] == x[4*i +: 4]) r[4*i +: 4] = 4'(v);
            end
        end
        return r;
    endfunction

    function automatic logic [63:0] m_mix(input logic [63:0] x);
        logic [63:0] r = '0;
        for (int b = 0; b < 4; b++) begin
            int s = (b == 1 || b == 2) ? 1 : 0;
            for (int n = 0; n < 4; n++) begin
                logic [15:0] t = x[16*b +: 16] & BMK[(s + 3 - n) % 4];
                for (int q = 0; q < 4; q++) r[16*b + 4*n +: 4] ^= t[4*q +: 4];
            end
        end
        return r;
    endfunction

    function automatic logic [63:0] m_shuf(input logic [63:0] x, input bit inv);
        logic [63:0] r;
        for (int n = 0; n < 16; n++) begin
            if (!inv) r[4*n +: 4] = x[4*BSR[n] +: 4];
            else      r[4*BSR[n] +: 4] = x[4*n +: 4];
        end
        return r;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] d, input logic [127:0] k, input int nh);
        logic [63:0] k0 = k[127:64];
        logic [63:0] k1 = k[63:0];
        logic [63:0] k0p = {k0[0], k0[63:1]} ^ {63'd0, k0[63]};
        logic [63:0] s = d ^ k0 ^ k1 ^ BRC[0];
        for (int r = 1; r <= nh; r++) begin
            s = m_shuf(m_mix(m_sub(s, 0)), 0) ^ BRC[r];
            s = s ^ ((r % 2 == 1) ? k0 : k1);
        end
        s = m_sub(m_mix(m_sub(s, 0)), 1);
        for (int j = 0; j < nh; j++) begin
            int r = 11 - nh + j;
            s = s ^ ((r % 2 == 1) ? k1 : k0) ^ BRC[r];
            s = m_sub(m_mix(m_shuf(s, 1)), 1);
        end
        return s ^ BRC[11] ^ k1 ^ k0p;
    endfunction

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [63:0]  d;
        logic [127:0] k;
        logic [63:0]  kat;
        logic         has_kat;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{64'h0, 128'h0, 64'h818665AA0D02DFDA, 1'b1},
        '{64'hFFFFFFFFFFFFFFFF, 128'h0, 64'h604AE6CA03C20ADA, 1'b1},
        '{64'h0123456789ABCDEF, 128'h0, 64'h0, 1'b0},
        '{64'h0, {64'hFFFFFFFFFFFFFFFF, 64'h0}, 64'h0, 1'b0},
        '{64'h0, {64'h0, 64'hFFFFFFFFFFFFFFFF}, 64'h0, 1'b0},
        '{64'hFEDCBA9876543210, 128'h00112233445566778899AABBCCDDEEFF, 64'h0, 1'b0},
        '{64'h0000000000000001, 128'h00112233445566778899AABBCCDDEEFF, 64'h0, 1'b0},
        '{64'h0000000000000001, 128'h80000000000000000000000000000001, 64'h0, 1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected < 5000 cycles", cyc);
            finish_run();
        end
    end

    logic [63:0] e5, e0, held5, held0, prev5;

    initial begin
        // Reset with noise on the inputs (R2)
        vld = 1'b1;
        din = 64'hDEADBEEFCAFEF00D;
        key = 128'h1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 valid", 64'(ov5), 64'd0);
        chk("R2 data", od5, 64'h0);
        chk("R2 data n0", od0, 64'h0);
        vld = 1'b0;
        rst_n = 1'b1;

        // Streamed table, one request per cycle (R1, R4..R12)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk("R1 back-to-back valid", 64'(ov5), 64'd1);
                if (VECS[i-1].has_kat) chk("R4 known answer", od5, e5);
                else chk("R5/R6/R7/R8/R9/R10/R11 model", od5, e5);
                chk("R12 zero half-rounds", od0, e0);
                if (i == 7) chk("R13 distinct", 64'(od5 != prev5), 64'd1);
                prev5 = od5;
            end
            vld = 1'b1;
            din = VECS[i].d;
            key = VECS[i].k;
            e5  = VECS[i].has_kat ? VECS[i].kat : model(VECS[i].d, VECS[i].k, 5);
            e0  = model(VECS[i].d, VECS[i].k, 0);
        end
        @(negedge clk);
        chk("R4/R5 last vector", od5, model(VECS[NV-1].d, VECS[NV-1].k, 5));
        chk("R12 last vector", od0, e0);
        held5 = od5;
        held0 = od0;

        // Idle cycles with moving inputs: hold and no valid (R1, R3)
        vld = 1'b0;
        for (int j = 0; j < 3; j++) begin
            din = 64'h1111111111111111 * 64'(j + 3);
            key = {din, ~din};
            @(negedge clk);
            chk("R1 valid low", 64'(ov5), 64'd0);
            chk("R3 hold", od5, held5);
            chk("R3 hold n0", od0, held0);
        end

        // Isolated pulse (R1)
        vld = 1'b1;
        din = 64'h0F0F0F0F0F0F0F0F;
        key = 128'h0123456789ABCDEF0123456789ABCDEF;
        @(negedge clk);
        chk("R1 pulse valid", 64'(ov5), 64'd1);
        chk("R5/R6/R8 pulse data", od5, model(din, key, 5));
        vld = 1'b0;
        @(negedge clk);
        chk("R1 pulse end", 64'(ov5), 64'd0);

        // Reset while busy (R2)
        vld = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R2 mid reset valid", 64'(ov5), 64'd0);
        chk("R2 mid reset data", od5, 64'h0);
        rst_n = 1'b1;
        vld = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule